// File: doc/BRIEF.md
# I2C Slave for a 16-bit Data Register

This block is the serial front end of a converter-style device that keeps one 16-bit data word. It watches the two lines of an I2C-compatible bus with a fast system clock. It detects Start, Repeated Start and Stop conditions. It decodes the address byte that follows each Start against an address supplied on a configuration input, and it answers with ACK or NACK. It drives the data line only through an open-drain enable.

In a write transaction the word arrives as byte pairs, upper byte first. The output register and a one-cycle update strobe change only once the lower byte of a pair has been acknowledged. A transaction may carry any number of pairs. If a Stop or Repeated Start cuts a pair in half, the lone upper byte is dropped. In a read transaction the current word is frozen when the address is acknowledged and is returned as two bytes, MSB first, paced by the master's ACK and NACK.

Top module: `pair_reg_i2c_slave`

## Requirements
- R1: While SCL is high, a falling SDA is a Start (or Repeated Start) and opens an address phase. A rising SDA is a Stop and returns the slave to idle. In idle, bytes clocked without a Start are neither acknowledged nor stored.
- R2: The eight bits after a Start are a 7-bit address, MSB first, then a direction bit (0 = write, 1 = read). If the address equals `dev_addr_i`, the slave asserts `sda_oe_o` (SDA pulled low) for the ninth clock.
- R3: On an address mismatch the slave leaves SDA released for the ninth clock. Until the next Start it acknowledges nothing, updates nothing, and reads back as all ones.
- R4: `sda_oe_o` = 1 pulls SDA low and 0 releases it. SDA is never driven high, and `sda_oe_o` changes only while SCL is low.
- R5: In a write, the first data byte is bits 15:8 and the second is bits 7:0. The slave ACKs both. `word_o` takes {upper, lower} and `word_stb_o` pulses for one cycle after the lower byte's ACK clock ends, never after the upper byte alone.
- R6: Further pairs in the same transaction each update `word_o` and each produce one strobe.
- R7: A Stop or Repeated Start that arrives after only an upper byte discards that byte. `word_o` keeps its value and no strobe occurs.
- R8: In a read, the slave sends bits 15:8 and then bits 7:0 of `word_o`, MSB first, as captured when the address was acknowledged.
- R9: A master ACK after the upper byte makes the slave send the lower byte. After a master NACK, or after the lower byte in any case, the slave releases SDA until the next Stop or Start.
- R10: During and after reset, `sda_oe_o`, `word_o` and `word_stb_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_addr_i | input | 7 | Slave address to match |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| word_o | output | 16 | Data register |
| word_stb_o | output | 1 | One-cycle pulse when `word_o` is updated |

## Verification
A wrong bit counter or state in the protocol engine shows up within one bus bit as an ACK in the wrong clock, a missing ACK, or SDA held low while the master expects it released. The master-side bench samples exactly those points. A fault in the pending-upper-byte flag of the pair register shows up only at the end of the next pair: a strobe arrives after a lone upper byte, or a word is assembled from a byte left over from an aborted transfer. The bench therefore counts strobes after every byte and reads the word back after each aborted and repeated-start sequence. A read-path shift fault corrupts the returned bytes in the same transaction.

// File: rtl/pr_i2c_pkg.sv
`timescale 1ns/1ps
package pr_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_WAIT
  } eng_state_e;
endpackage

// File: rtl/pr_i2c_rst_sync.sv
`timescale 1ns/1ps
module pr_i2c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/pr_i2c_line_mon.sv
`timescale 1ns/1ps
module pr_i2c_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;
  localparam int IDX_SCL = 0;
  localparam int IDX_SDA = 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;
    always_comb ff_d = {ff_q[STAGES-2:0], raw[g]};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= ff_d;
    end
    assign synced[g] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= synced;
  end

  assign scl_s_o    = synced[IDX_SCL];
  assign sda_s_o    = synced[IDX_SDA];
  assign scl_rise_o = synced[IDX_SCL] & ~prev_q[IDX_SCL];
  assign scl_fall_o = ~synced[IDX_SCL] & prev_q[IDX_SCL];
  assign start_o    = synced[IDX_SCL] & prev_q[IDX_SCL] &
                      prev_q[IDX_SDA] & ~synced[IDX_SDA];
  assign stop_o     = synced[IDX_SCL] & prev_q[IDX_SCL] &
                      ~prev_q[IDX_SDA] & synced[IDX_SDA];
endmodule

// File: rtl/pr_i2c_engine.sv
`timescale 1ns/1ps
module pr_i2c_engine
  import pr_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sda_oe_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              pair_clr_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  eng_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic              oe_q, oe_d;
  logic              rdsel_q, rdsel_d;
  logic              mack_q, mack_d;
  logic              vld_q, vld_d;
  logic              clr_q, clr_d;
  logic              shift_in;
  logic              byte_full;

  assign shift_in  = scl_rise_i && (cnt_q < CNT_FULL);
  assign byte_full = scl_fall_i && (cnt_q == CNT_FULL);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    oe_d    = oe_q;
    rdsel_d = rdsel_q;
    mack_d  = mack_q;
    vld_d   = 1'b0;
    clr_d   = 1'b0;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      clr_d   = 1'b1;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      clr_d   = 1'b1;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (shift_in) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s_i};
            cnt_d = cnt_q + 1'b1;
          end
          if (byte_full) begin
            if (sh_q[BYTE_W-1:1] == dev_addr_i) begin
              state_d = ST_ADDR_ACK;
              oe_d    = 1'b1;
              tx_d    = word_i;
              rdsel_d = 1'b0;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_d = '0;
            if (sh_q[0]) begin
              state_d = ST_RD_BYTE;
              oe_d    = ~tx_q[WORD_W-1];
            end else begin
              state_d = ST_WR_BYTE;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WR_BYTE: begin
          if (shift_in) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s_i};
            cnt_d = cnt_q + 1'b1;
          end
          if (byte_full) begin
            state_d = ST_WR_ACK;
            oe_d    = 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            state_d = ST_WR_BYTE;
            oe_d    = 1'b0;
            cnt_d   = '0;
            vld_d   = 1'b1;
          end
        end
        ST_RD_BYTE: begin
          if (shift_in) cnt_d = cnt_q + 1'b1;
          if (scl_fall_i && (cnt_q != '0)) begin
            tx_d = {tx_q[WORD_W-2:0], 1'b0};
            if (cnt_q == CNT_FULL) begin
              state_d = ST_RD_ACK;
              oe_d    = 1'b0;
            end else begin
              oe_d = ~tx_q[WORD_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) mack_d = sda_s_i;
          if (scl_fall_i) begin
            if (!mack_q && !rdsel_q) begin
              state_d = ST_RD_BYTE;
              rdsel_d = 1'b1;
              cnt_d   = '0;
              oe_d    = ~tx_q[WORD_W-1];
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      rdsel_q <= 1'b0;
      mack_q  <= 1'b1;
      vld_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      oe_q    <= oe_d;
      rdsel_q <= rdsel_d;
      mack_q  <= mack_d;
      vld_q   <= vld_d;
      clr_q   <= clr_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign byte_vld_o = vld_q;
  assign byte_o     = sh_q;
  assign pair_clr_o = clr_q;

  // R4: the data line only moves while the clock line is low
  p_oe_scl_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> !scl_s_i);
  // R1: a stop always lands in idle
  p_stop_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state_q == ST_IDLE));
  // R2, R5: acknowledge phases hold the line low
  p_ack_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ADDR_ACK) || (state_q == ST_WR_ACK)) |-> oe_q);
  // R3, R9: a silenced slave never pulls the line
  p_wait_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !oe_q);
endmodule

// File: rtl/pr_i2c_pair_reg.sv
`timescale 1ns/1ps
module pr_i2c_pair_reg
  import pr_i2c_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              stb_o
);
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic              have_q, have_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              stb_q, stb_d;

  always_comb begin
    hi_d   = hi_q;
    have_d = have_q;
    word_d = word_q;
    stb_d  = 1'b0;
    if (clr_i) begin
      have_d = 1'b0;
    end else if (byte_vld_i) begin
      if (!have_q) begin
        hi_d   = byte_i;
        have_d = 1'b1;
      end else begin
        word_d = {hi_q, byte_i};
        stb_d  = 1'b1;
        have_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      have_q <= 1'b0;
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      hi_q   <= hi_d;
      have_q <= have_d;
      word_q <= word_d;
      stb_q  <= stb_d;
    end
  end

  assign word_o = word_q;
  assign stb_o  = stb_q;

  // R5: strobe lasts one cycle
  p_stb_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  // R7: the word never moves without a strobe
  p_word_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_q != $past(word_q)) |-> stb_q);
  // R7: a clear never produces an update
  p_clear_no_stb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !stb_q);
endmodule

// File: rtl/pair_reg_i2c_slave.sv
`timescale 1ns/1ps
module pair_reg_i2c_slave
  import pr_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_stb_o
);
  logic              rst_n_s;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              byte_vld, pair_clr;
  logic [BYTE_W-1:0] byte_val;

  pr_i2c_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  pr_i2c_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s_o   (scl_s),
    .sda_s_o   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  pr_i2c_engine u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .dev_addr_i(dev_addr_i),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .word_i    (word_o),
    .sda_oe_o  (sda_oe_o),
    .byte_vld_o(byte_vld),
    .byte_o    (byte_val),
    .pair_clr_o(pair_clr)
  );

  pr_i2c_pair_reg u_pair (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .byte_vld_i(byte_vld),
    .byte_i    (byte_val),
    .clr_i     (pair_clr),
    .word_o    (word_o),
    .stb_o     (word_stb_o)
  );
endmodule

// File: tb/sim_pair_reg_i2c_slave.sv
`timescale 1ns/1ps
module sim_pair_reg_i2c_slave;
  localparam int Q = 10;
  localparam logic [6:0] ADDR_A = 7'h4C;
  localparam logic [6:0] ADDR_B = 7'h13;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'hA55A, 16'h0000, 16'hFFFF,
                                       16'h8001, 16'h1234, 16'h7FFE};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  dev_addr = ADDR_A;
  logic        scl_m = 1'b1;
  logic        m_low = 1'b0;
  logic        sda_oe;
  logic [15:0] word;
  logic        word_stb;
  logic        sda_bus;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  int oe_bad = 0;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  assign sda_bus = !(m_low || sda_oe);

  always #2 clk = ~clk;

  pair_reg_i2c_slave u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .dev_addr_i(dev_addr),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .word_o    (word),
    .word_stb_o(word_stb)
  );

  always @(posedge clk) begin
    oe_prev <= sda_oe;
    if (word_stb) stb_cnt <= stb_cnt + 1;
    if ((sda_oe != oe_prev) && scl_m) oe_bad <= oe_bad + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    if (!scl_m) begin
      m_low = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
    end
    m_low = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; tick(Q);
      scl_m = 1'b1;  tick(2 * Q);
      scl_m = 1'b0;  tick(Q);
    end
    m_low = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b);
    m_low = 1'b0;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_bus}; tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    m_low = mack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    m_low = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit a, a2;
    logic [7:0] b1, b2, b3;
    int s0;
    logic [15:0] w0;

    tick(3);
    chk("R10 oe in reset", 32'(sda_oe), 32'd0);
    chk("R10 word in reset", 32'(word), 32'd0);
    rst_n = 1'b1;
    tick(5);
    chk("R10 oe after reset", 32'(sda_oe), 32'd0);
    chk("R10 word after reset", 32'(word), 32'd0);
    chk("R10 strobe after reset", 32'(word_stb), 32'd0);

    // Vector table: write one pair, read it back
    for (int i = 0; i < NV; i++) begin
      s0 = stb_cnt;
      i2c_start();
      send_byte({ADDR_A, 1'b0}, a);
      chk("R2 write address ack", 32'(a), 32'd1);
      send_byte(VEC[i][15:8], a);
      chk("R5 upper byte ack", 32'(a), 32'd1);
      chk("R5 no strobe after upper", 32'(stb_cnt), 32'(s0));
      send_byte(VEC[i][7:0], a);
      chk("R5 lower byte ack", 32'(a), 32'd1);
      chk("R5 one strobe after lower", 32'(stb_cnt), 32'(s0 + 1));
      chk("R5 word value", 32'(word), 32'(VEC[i]));
      i2c_stop();
      i2c_start();
      send_byte({ADDR_A, 1'b1}, a);
      chk("R2 read address ack", 32'(a), 32'd1);
      read_byte(1'b1, b1);
      read_byte(1'b0, b2);
      chk("R8 read word", 32'({b1, b2}), 32'(VEC[i]));
      chk("R9 released after nack", 32'(sda_oe), 32'd0);
      i2c_stop();
    end

    // R6: two pairs inside one transaction
    s0 = stb_cnt;
    i2c_start();
    send_byte({ADDR_A, 1'b0}, a);
    send_byte(8'h13, a);
    send_byte(8'h57, a);
    chk("R6 first pair word", 32'(word), 32'h1357);
    send_byte(8'hBE, a);
    send_byte(8'hEF, a);
    chk("R6 second pair ack", 32'(a), 32'd1);
    chk("R6 second pair word", 32'(word), 32'hBEEF);
    chk("R6 two strobes", 32'(stb_cnt), 32'(s0 + 2));
    i2c_stop();

    // R7: lone upper byte then stop
    s0 = stb_cnt;
    i2c_start();
    send_byte({ADDR_A, 1'b0}, a);
    send_byte(8'h99, a);
    i2c_stop();
    tick(Q);
    chk("R7 word kept after stop", 32'(word), 32'hBEEF);
    chk("R7 no strobe after stop", 32'(stb_cnt), 32'(s0));

    // R7 and R1: lone upper byte then repeated start
    i2c_start();
    send_byte({ADDR_A, 1'b0}, a);
    send_byte(8'h44, a);
    i2c_start();
    send_byte({ADDR_A, 1'b0}, a);
    chk("R1 ack after repeated start", 32'(a), 32'd1);
    chk("R7 word kept at restart", 32'(word), 32'hBEEF);
    send_byte(8'h12, a);
    send_byte(8'h34, a);
    chk("R7 stale upper byte dropped", 32'(word), 32'h1234);
    i2c_stop();

    // R9: master ACKs both bytes, then an extra byte
    i2c_start();
    send_byte({ADDR_A, 1'b1}, a);
    read_byte(1'b1, b1);
    read_byte(1'b1, b2);
    read_byte(1'b0, b3);
    chk("R9 bytes with ack", 32'({b1, b2}), 32'h1234);
    chk("R9 released after lower", 32'(b3), 32'hFF);
    i2c_stop();

    // R9: master NACKs the upper byte
    i2c_start();
    send_byte({ADDR_A, 1'b1}, a);
    read_byte(1'b0, b1);
    chk("R9 upper byte", 32'(b1), 32'h12);
    chk("R9 oe after nack", 32'(sda_oe), 32'd0);
    read_byte(1'b0, b2);
    chk("R9 silent after nack", 32'(b2), 32'hFF);
    i2c_stop();

    // R3: address mismatch, write and read
    s0 = stb_cnt;
    w0 = word;
    i2c_start();
    send_byte({ADDR_A ^ 7'h01, 1'b0}, a);
    chk("R3 nack on mismatch", 32'(a), 32'd0);
    send_byte(8'hAA, a);
    send_byte(8'h55, a2);
    chk("R3 no data ack", 32'({a, a2}), 32'd0);
    chk("R3 no strobe", 32'(stb_cnt), 32'(s0));
    chk("R3 word unchanged", 32'(word), 32'(w0));
    i2c_stop();
    i2c_start();
    send_byte({ADDR_A ^ 7'h40, 1'b1}, a);
    read_byte(1'b0, b1);
    chk("R3 read nack", 32'(a), 32'd0);
    chk("R3 read all ones", 32'(b1), 32'hFF);
    i2c_stop();

    // R1: bytes clocked in idle without a start
    scl_m = 1'b0; tick(Q);
    send_byte({ADDR_A, 1'b0}, a);
    chk("R1 no ack without start", 32'(a), 32'd0);
    i2c_stop();

    // R2: the address input is honoured
    dev_addr = ADDR_B;
    tick(Q);
    i2c_start();
    send_byte({ADDR_A, 1'b0}, a);
    chk("R2 old address rejected", 32'(a), 32'd0);
    i2c_start();
    send_byte({ADDR_B, 1'b0}, a);
    chk("R2 new address accepted", 32'(a), 32'd1);
    send_byte(8'hC0, a);
    send_byte(8'hDE, a);
    chk("R2 write at new address", 32'(word), 32'hC0DE);
    i2c_stop();

    chk("R4 oe changes only with scl low", 32'(oe_bad), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule